// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial memory. It keeps 256 bytes in a synchronous register array that stands in for nonvolatile cells. The SCL and SDA pins arrive as raw inputs and are sampled in the system clock domain. The block drives SDA only by pulling it low through an open-drain enable. It finds START and STOP conditions on the bus and answers one device address. The upper nibble of that address is fixed and the next three bits come from a select input. The block accepts byte and page writes and serves current-address, random and sequential reads.

Write data is not stored as it arrives. It collects in a one-page buffer and goes into the array only when a STOP closes the transaction. The STOP also starts a self-timed busy window, counted in system clocks. While the window runs the block leaves the bus alone and never acknowledges its address, so a master can poll until the write has finished. A START that comes in the middle of any transfer drops that transfer and begins address reception again. A write cut short this way changes nothing in the array.

Top module: `eep_i2c_slave`

## Requirements
- R1: After reset `sda_drive_low` is 0, every array byte reads 0x00 and the address pointer is 0, so the first current-address read returns the byte at address 0.
- R2: SDA falling while SCL is high is a START and SDA rising while SCL is high is a STOP. A START in the middle of a byte drops it and restarts reception with the device address byte.
- R3: The device byte matches when bits 7:4 are 1010 and bits 3:1 equal `chip_sel`. Bit 0 selects the direction, 1 for read and 0 for write. On a match the slave pulls SDA low on the ninth clock. On a mismatch it does not acknowledge and ignores all bytes until the next START.
- R4: A byte write is the device byte (write), one word-address byte, then one data byte, each acknowledged. After the write completes, a random read of that address returns the data.
- R5: A page write acknowledges every data byte. Each byte goes to the column given by the low 3 address bits, and the column wraps within the 8-byte page. Bytes past the eighth overwrite earlier columns, and no byte lands outside the page.
- R6: The array is written only after a STOP. A transaction ended by a START writes nothing, and a STOP with no data byte starts no busy window.
- R7: For WRITE_CYCLES system clocks after a write's STOP, every bus input is ignored and the device byte gets no acknowledge. Once the window ends the device byte is acknowledged again.
- R8: In a sequential read each byte acknowledged by the master is followed by the next address. The address wraps from 0xFF to 0x00.
- R9: A current-address read returns the byte at one past the last address read or written. After a page write that address wraps within the page.
- R10: When the master does not acknowledge a read byte, the slave stops driving SDA and stays silent until the next START.
- R11: Read data leaves MSB first. The slave changes `sda_drive_low` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw serial clock from the bus |
| sda_in | input | 1 | Raw serial data as seen on the wired bus |
| chip_sel | input | 3 | Select bits compared with device byte bits 3:1 |
| sda_drive_low | output | 1 | Open-drain enable, 1 pulls SDA low |

## Verification
The assertions assume that each SCL phase lasts long enough for the two-flop synchroniser and the edge register to see it, which means at least a few system clocks. They assume the master moves SDA only after SCL has been low for two clocks, and never tries a START or STOP while the slave holds SDA low. They also assume WRITE_CYCLES is at least the page size, so that the commit of the page buffer finishes inside the busy window. The bench holds each SCL phase for 8 system clocks and waits 2 clocks after every SCL falling edge before touching SDA. It releases SDA on every ninth clock where the slave answers.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } eep_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_WORD,
        K_DATA
    } eep_kind_e;

    localparam logic [3:0] EEP_FAMILY = 4'b1010;

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= {ff_q[STAGES-2:0], d};
    end

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells_q[i] <= '0;
            rdata_q <= '0;
        end else begin
            if (we) cells_q[waddr] <= wdata;
            rdata_q <= cells_q[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/eep_wtimer.sv
module eep_wtimer #(
    parameter int CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (go)                 cnt_d = CNT_W'(CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int PAGE_BYTES   = 8,
    parameter int WRITE_CYCLES = 250000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] chip_sel,
    output logic       sda_drive_low
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int ROW_W  = ADDR_W - PAGE_W;
    localparam int PINS   = 2;

    typedef struct packed {
        eep_state_e                  st;
        eep_kind_e                   kind;
        logic [2:0]                  bitcnt;
        logic                        byte_done;
        logic [7:0]                  sr;
        logic                        rw;
        logic                        mack;
        logic                        drive;
        logic [ADDR_W-1:0]           addr;
        logic [7:0]                  tx;
        logic [PAGE_BYTES-1:0][7:0]  pbuf;
        logic [PAGE_BYTES-1:0]       pvalid;
        logic [ROW_W-1:0]            prow;
        logic                        commit;
        logic [PAGE_W-1:0]           cslot;
        logic                        scl_p;
        logic                        sda_p;
    } regs_t;

    regs_t d, q;

    // synchronised pins: index 1 = SCL, index 0 = SDA
    logic [PINS-1:0] raw_pins, sync_pins;
    assign raw_pins = {scl_in, sda_in};

    for (genvar g = 0; g < PINS; g++) begin : g_sync
        eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_pins[g]),
            .q     (sync_pins[g])
        );
    end

    logic scl_s, sda_s;
    assign scl_s = sync_pins[1];
    assign sda_s = sync_pins[0];

    logic start_ev, stop_ev, scl_rise, scl_fall;
    assign start_ev = q.scl_p & scl_s &  q.sda_p & ~sda_s;
    assign stop_ev  = q.scl_p & scl_s & ~q.sda_p &  sda_s;
    assign scl_rise =  scl_s & ~q.scl_p;
    assign scl_fall = ~scl_s &  q.scl_p;

    logic              busy, timer_go;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata, mem_rdata;
    logic              fsm_idle;

    assign mem_we    = q.commit & q.pvalid[q.cslot];
    assign mem_waddr = {q.prow, q.cslot};
    assign mem_wdata = q.pbuf[q.cslot];
    assign fsm_idle  = (q.st == ST_IDLE);

    eep_store #(.ADDR_W(ADDR_W), .DATA_W(8)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (q.addr),
        .rdata (mem_rdata)
    );

    eep_wtimer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (timer_go),
        .busy  (busy)
    );

    always_comb begin
        d        = q;
        timer_go = 1'b0;
        d.scl_p  = scl_s;
        d.sda_p  = sda_s;

        if (q.commit) begin
            // drain the page buffer into the array, one column per clock
            if (q.cslot == PAGE_W'(PAGE_BYTES - 1)) begin
                d.commit = 1'b0;
                d.pvalid = '0;
            end else begin
                d.cslot = q.cslot + 1'b1;
            end
        end else if (!busy) begin
            if (start_ev) begin
                d.st        = ST_RX;
                d.kind      = K_DEV;
                d.bitcnt    = '0;
                d.byte_done = 1'b0;
                d.drive     = 1'b0;
                d.pvalid    = '0;
            end else if (stop_ev) begin
                d.st    = ST_IDLE;
                d.drive = 1'b0;
                if (|q.pvalid) begin
                    d.commit = 1'b1;
                    d.cslot  = '0;
                    timer_go = 1'b1;
                end
            end else begin
                unique case (q.st)
                    ST_RX: begin
                        if (scl_rise) begin
                            d.sr = {q.sr[6:0], sda_s};
                            if (q.bitcnt == 3'd7) d.byte_done = 1'b1;
                            else                  d.bitcnt    = q.bitcnt + 1'b1;
                        end else if (scl_fall && q.byte_done) begin
                            d.byte_done = 1'b0;
                            d.bitcnt    = '0;
                            unique case (q.kind)
                                K_DEV: begin
                                    if (q.sr[7:4] == EEP_FAMILY && q.sr[3:1] == chip_sel) begin
                                        d.rw    = q.sr[0];
                                        d.st    = ST_ACK;
                                        d.drive = 1'b1;
                                    end else begin
                                        d.st = ST_IDLE;
                                    end
                                end
                                K_WORD: begin
                                    d.addr  = q.sr[ADDR_W-1:0];
                                    d.prow  = q.sr[ADDR_W-1:PAGE_W];
                                    d.st    = ST_ACK;
                                    d.drive = 1'b1;
                                end
                                default: begin
                                    d.pbuf[q.addr[PAGE_W-1:0]]   = q.sr;
                                    d.pvalid[q.addr[PAGE_W-1:0]] = 1'b1;
                                    d.addr  = {q.addr[ADDR_W-1:PAGE_W],
                                               q.addr[PAGE_W-1:0] + 1'b1};
                                    d.st    = ST_ACK;
                                    d.drive = 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            d.drive = 1'b0;
                            if (q.kind == K_DEV && q.rw) begin
                                d.st     = ST_TX;
                                d.tx     = mem_rdata;
                                d.drive  = ~mem_rdata[7];
                                d.bitcnt = '0;
                            end else begin
                                d.st   = ST_RX;
                                d.kind = (q.kind == K_DEV) ? K_WORD : K_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (q.bitcnt == 3'd7) begin
                                d.st    = ST_MACK;
                                d.drive = 1'b0;
                                d.addr  = q.addr + 1'b1;
                                d.mack  = 1'b0;
                            end else begin
                                d.bitcnt = q.bitcnt + 1'b1;
                                d.tx     = {q.tx[6:0], 1'b0};
                                d.drive  = ~q.tx[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            d.mack = ~sda_s;
                        end else if (scl_fall) begin
                            if (q.mack) begin
                                d.st     = ST_TX;
                                d.tx     = mem_rdata;
                                d.drive  = ~mem_rdata[7];
                                d.bitcnt = '0;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_drive_low = q.drive;
endmodule

// File: rtl/eep_checks.sv
module eep_checks (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic busy,
    input logic mem_we,
    input logic drive,
    input logic fsm_idle
);
    AST_SILENT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !drive);                                                   // R7

    AST_ARRAY_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);                                                   // R6

    AST_IDLE_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle |-> !drive);                                               // R10

    AST_DRIVE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (drive != $past(drive)) |-> !scl_s);                                // R11
endmodule

bind eep_i2c_slave eep_checks u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .busy     (busy),
    .mem_we   (mem_we),
    .drive    (sda_drive_low),
    .fsm_idle (fsm_idle)
);

// File: tb/eep_i2c_slave_test.sv
module eep_i2c_slave_test;
    localparam int         CLK_NS = 10;
    localparam int         HALF   = 8;
    localparam int         WCYC   = 1000;
    localparam logic [2:0] SEL    = 3'b101;
    localparam int         NVEC   = 6;
    // each entry: {word address, data}
    localparam logic [15:0] VECS [NVEC] = '{16'h0080, 16'hFF01, 16'h2AC3,
                                            16'h7E3C, 16'h81A5, 16'h550F};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive_low;
    logic sda_line;
    int   total = 0;
    int   bad = 0;
    logic [7:0] shadow [256];

    assign sda_line = sda_m & ~sda_drive_low;

    always #(CLK_NS/2) clk = ~clk;

    eep_i2c_slave #(.WRITE_CYCLES(WCYC)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_m),
        .sda_in        (sda_line),
        .chip_sel      (SEL),
        .sda_drive_low (sda_drive_low)
    );

    initial begin
        repeat (150000) @(negedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dev(input logic rw);
        return {4'b1010, SEL, rw};
    endfunction

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(HALF);
        scl_m = 1'b1; wt(HALF);
        sda_m = 1'b0; wt(HALF);
        scl_m = 1'b0; wt(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(HALF);
        scl_m = 1'b1; wt(HALF);
        sda_m = 1'b1; wt(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wt(HALF);
            scl_m = 1'b1; wt(HALF);
            scl_m = 1'b0; wt(2);
        end
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        sda_m = 1'b1; wt(HALF);
        scl_m = 1'b1; wt(HALF/2);
        acked = ~sda_line;
        wt(HALF - HALF/2);
        scl_m = 1'b0; wt(2);
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(HALF);
            scl_m = 1'b1; wt(HALF/2);
            b[i] = sda_line;
            wt(HALF - HALF/2);
            scl_m = 1'b0; wt(2);
        end
        sda_m = ~give_ack; wt(HALF);
        scl_m = 1'b1; wt(HALF);
        scl_m = 1'b0; wt(2);
        sda_m = 1'b1;
    endtask

    task automatic byte_write(input logic [7:0] a, input logic [7:0] v, output logic [2:0] acks);
        bus_start();
        put_byte(dev(1'b0), acks[2]);
        put_byte(a, acks[1]);
        put_byte(v, acks[0]);
        bus_stop();
    endtask

    task automatic wait_ready(output int polls);
        logic ack;
        polls = 0;
        do begin
            polls++;
            bus_start();
            put_byte(dev(1'b0), ack);
            bus_stop();
        end while (!ack && polls < 40);
    endtask

    task automatic read_at(input logic [7:0] a, output logic [7:0] b);
        logic ack;
        bus_start();
        put_byte(dev(1'b0), ack);
        put_byte(a, ack);
        bus_start();
        put_byte(dev(1'b1), ack);
        get_byte(1'b0, b);
        bus_stop();
    endtask

    initial begin
        logic       ack;
        logic [2:0] acks;
        logic [7:0] b, b2;
        int         polls, highs;

        for (int i = 0; i < 256; i++) shadow[i] = 8'h00;

        wt(5);
        chk("R1 drive low during reset", sda_drive_low, 0);
        rst_n = 1'b1;
        wt(4);
        chk("R1 drive low after reset", sda_drive_low, 0);

        // R1: current-address read right after reset hits address 0
        bus_start();
        put_byte(dev(1'b1), ack);
        chk("R1 read address ack", ack, 1);
        get_byte(1'b0, b);
        bus_stop();
        chk("R1 reset contents at 0", b, 8'h00);

        // R3: mismatching select bits, then wrong family nibble
        bus_start();
        put_byte({4'b1010, 3'b011, 1'b0}, ack);
        chk("R3 select mismatch nack", ack, 0);
        put_byte(8'h12, ack);
        chk("R3 bytes ignored after mismatch", ack, 0);
        bus_stop();
        bus_start();
        put_byte({4'b1011, SEL, 1'b0}, ack);
        chk("R3 family mismatch nack", ack, 0);
        bus_stop();

        // R4 / R11: byte write then random read, table of vectors
        for (int i = 0; i < NVEC; i++) begin
            byte_write(VECS[i][15:8], VECS[i][7:0], acks);
            chk("R4 byte write acks", acks, 3'b111);
            shadow[VECS[i][15:8]] = VECS[i][7:0];
            wait_ready(polls);
            read_at(VECS[i][15:8], b);
            chk("R4 R11 random read data msb first", b, VECS[i][7:0]);
        end

        // R8: sequential read wraps 0xFF -> 0x00
        bus_start();
        put_byte(dev(1'b0), ack);
        put_byte(8'hFF, ack);
        bus_start();
        put_byte(dev(1'b1), ack);
        get_byte(1'b1, b);
        get_byte(1'b0, b2);
        bus_stop();
        chk("R8 sequential byte at FF", b, shadow[8'hFF]);
        chk("R8 sequential wrap to 00", b2, shadow[8'h00]);

        // R7: write ignored while busy, polling nacks then acks
        byte_write(8'h30, 8'h77, acks);
        shadow[8'h30] = 8'h77;
        byte_write(8'h30, 8'h11, acks);
        chk("R7 write during busy nacked", acks, 3'b000);
        wait_ready(polls);
        chk("R7 first poll nacked", int'(polls >= 2), 1);
        chk("R7 poll acked after window", int'(polls < 40), 1);
        read_at(8'h30, b);
        chk("R7 busy write had no effect", b, 8'h77);

        // R5: page write of 10 bytes from column 3 of page 0x10
        bus_start();
        put_byte(dev(1'b0), ack);
        put_byte(8'h13, ack);
        acks = 3'b111;
        for (int k = 0; k < 10; k++) begin
            put_byte(8'hD0 + 8'(k), ack);
            if (!ack) acks = 3'b000;
            shadow[8'h10 + ((3 + k) % 8)] = 8'hD0 + 8'(k);
        end
        bus_stop();
        chk("R5 every page byte acked", acks, 3'b111);
        wait_ready(polls);

        // R9: pointer sits one past the last written column (0x15)
        bus_start();
        put_byte(dev(1'b1), ack);
        get_byte(1'b0, b);
        bus_stop();
        chk("R9 current address after page write", b, shadow[8'h15]);

        bus_start();
        put_byte(dev(1'b0), ack);
        put_byte(8'h10, ack);
        bus_start();
        put_byte(dev(1'b1), ack);
        for (int k = 0; k < 9; k++) begin
            get_byte(k != 8, b);
            chk("R5 page contents and no spill", b, shadow[8'h10 + k]);
        end
        bus_stop();

        // R6: write cut by START commits nothing and starts no busy window
        bus_start();
        put_byte(dev(1'b0), ack);
        put_byte(8'h40, ack);
        put_byte(8'hAA, ack);
        bus_start();
        bus_stop();
        wait_ready(polls);
        chk("R6 no busy after aborted write", polls, 1);
        read_at(8'h40, b);
        chk("R6 aborted write not stored", b, 8'h00);

        // R2: START in the middle of a byte restarts address reception
        bus_start();
        send_bits(dev(1'b0), 3);
        bus_start();
        put_byte(dev(1'b1), ack);
        chk("R2 address after mid-byte start acked", ack, 1);
        get_byte(1'b0, b);
        bus_stop();
        chk("R2 read after restart", b, shadow[8'h41]);

        // R10: after master nack the slave stays off the bus
        bus_start();
        put_byte(dev(1'b0), ack);
        put_byte(8'h2A, ack);
        bus_start();
        put_byte(dev(1'b1), ack);
        get_byte(1'b0, b);
        chk("R10 read data before nack", b, shadow[8'h2A]);
        highs = 0;
        for (int k = 0; k < 9; k++) begin
            wt(HALF);
            scl_m = 1'b1; wt(HALF/2);
            if (sda_line) highs++;
            wt(HALF - HALF/2);
            scl_m = 1'b0; wt(2);
        end
        chk("R10 sda released after nack", highs, 9);
        bus_stop();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule